// File: doc/BRIEF.md
# USB IN Endpoint NAK and Disable Controller

This block keeps the control and status state of one device-mode IN endpoint in a full-speed USB device core. Software issues register-style commands on a single write strobe: request NAK, release NAK, enable and disable. A separate strobe starts a flush of one transmit FIFO. The block records NAK status, the enable and disable bits, two interrupt flags with masks, and a running count of the packets and bytes the endpoint has sent.

A simplified token interface stands in for the serial engine. For each IN token the block returns a registered DATA or NAK answer. A later completion pulse marks the end of the packet on the wire. A NAK request only takes hold once no packet is on the wire. This is why software waits for the NAK-effective flag before it treats the endpoint as quiet. Disabling is a handshake: software asks for it, and the block clears the enable and disable bits itself when it finishes.

Top module: `in_ep_ctrl`

## Requirements
- R1: After reset the endpoint is disabled, NAK status is 0, both interrupt flags are 0, no flush is busy, no FIFO is forced empty, and both counters are 0.
- R2: A write with the set-NAK bit records a NAK request. NAK status and the NAK-effective flag rise together, one cycle after the request has been recorded, provided no packet is in flight (a DATA answer has been given and the completion pulse has not yet come) and no DATA answer is being given in that cycle. After an idle write they are therefore seen two cycles after the write.
- R3: An IN token is answered in the next cycle with resp_valid=1 and resp_data=1 for DATA or 0 for NAK. DATA is given only when the endpoint is enabled, NAK status is 0, tx_ready is 1 and no packet is in flight. A DATA answer may still be given after a NAK request while NAK status is still 0.
- R4: Each interrupt output equals its flag ANDed with its unmask input. Masking never changes the flag.
- R5: A write with the clear-NAK bit (and set-NAK at 0) clears the NAK request, the NAK status and the NAK-effective flag in one cycle. When both bits are written together, set-NAK wins and clear-NAK is ignored.
- R6: A disable request is accepted only when the disable bit and the set-NAK bit are written together while the endpoint is enabled. Any other disable write leaves ep_dis at 0.
- R7: With a disable pending, the first cycle that has NAK status at 1 and no packet in flight clears ep_ena and ep_dis and sets the endpoint-disabled flag, all on the same edge.
- R8: Each DATA answer adds 1 to sent_pkts and tok_len to sent_bytes (modulo their widths). The counts keep their values through a disable. An enable write while the endpoint is disabled sets them to 0. An enable write while the endpoint is enabled has no effect.
- R9: A flush write while no flush is busy sets flush_busy for exactly FLUSH_CYC cycles. During that time fifo_force_empty has only the bit of the selected FIFO set (bit i for FIFO number i). A flush write while a flush is busy is ignored.
- R10: Writing 1 to a flag-clear bit clears that flag. A flag-setting event in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control command write strobe |
| ctl_snak | input | 1 | Command bit: request NAK |
| ctl_cnak | input | 1 | Command bit: release NAK |
| ctl_ena | input | 1 | Command bit: enable endpoint |
| ctl_dis | input | 1 | Command bit: disable endpoint |
| int_clr_wr | input | 1 | Flag clear write strobe |
| int_clr_nakeff | input | 1 | Write 1 to clear the NAK-effective flag |
| int_clr_disdone | input | 1 | Write 1 to clear the endpoint-disabled flag |
| unmask_nakeff | input | 1 | 1 lets the NAK-effective interrupt out |
| unmask_disdone | input | 1 | 1 lets the endpoint-disabled interrupt out |
| flush_wr | input | 1 | Flush request strobe |
| flush_sel | input | FIFO_W | Number of the FIFO to flush |
| tok_in | input | 1 | IN token arrived |
| tok_len | input | LEN_W | Byte length of the packet that a DATA answer sends |
| tx_ready | input | 1 | Data is available to send |
| pkt_done | input | 1 | Packet on the wire has completed |
| resp_valid | output | 1 | Token answer valid |
| resp_data | output | 1 | 1 means DATA, 0 means NAK |
| nak_sts | output | 1 | NAK status |
| ep_ena | output | 1 | Endpoint enabled |
| ep_dis | output | 1 | Disable pending |
| flag_nakeff | output | 1 | NAK-effective flag |
| flag_disdone | output | 1 | Endpoint-disabled flag |
| irq_nakeff | output | 1 | Masked NAK-effective interrupt |
| irq_disdone | output | 1 | Masked endpoint-disabled interrupt |
| sent_pkts | output | PKT_W | Packets sent since the last enable |
| sent_bytes | output | BYTE_W | Bytes sent since the last enable |
| flush_busy | output | 1 | Flush in progress; clears itself |
| fifo_force_empty | output | NUM_FIFO | Per-FIFO forced-empty level |

## Verification
Directed sequences place the NAK request in three positions relative to a packet: with none on the wire, while one is in flight, and just ahead of the completion pulse. They show whether the NAK status waits for the packet boundary or jumps ahead of it. Disable writes are tried with and without the set-NAK bit, and on both an enabled and a disabled endpoint. These runs separate a correct handshake from one that takes a bare disable or leaves one of the two bits set. A long stretch of seeded random strobes mixes tokens, completions, commands, flag clears and flushes. It is compared cycle by cycle against a bench model, so that ordering conflicts are covered: a set and a clear in the same cycle, a flush write while a flush is busy, and an enable write on an enabled endpoint.

// File: rtl/in_ep_pkg.sv
package in_ep_pkg;

  typedef enum logic {
    RESP_NAK  = 1'b0,
    RESP_DATA = 1'b1
  } resp_e;

  typedef struct packed {
    logic snak;
    logic cnak;
    logic ena;
    logic dis;
  } ctl_cmd_t;

endpackage

// File: rtl/in_ep_state.sv
module in_ep_state
  import in_ep_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ctl_wr,
  input  ctl_cmd_t cmd,
  input  logic     clr_wr,
  input  logic     clr_nakeff,
  input  logic     clr_disdone,
  input  logic     tok_in,
  input  logic     tx_ready,
  input  logic     pkt_done,
  output logic     resp_valid,
  output logic     resp_data,
  output logic     nak_sts,
  output logic     ep_ena,
  output logic     ep_dis,
  output logic     flag_nakeff,
  output logic     flag_disdone,
  output logic     data_fire,
  output logic     ena_start
);

  logic  nak_req_q, nak_sts_q, ena_q, dis_q, infl_q;
  logic  flag_nak_q, flag_dis_q, resp_valid_q;
  resp_e resp_q;

  // named internal events
  logic set_nak, rel_nak, dis_accept, nak_evt, dis_evt;

  assign set_nak    = ctl_wr && cmd.snak;
  assign rel_nak    = ctl_wr && cmd.cnak && !cmd.snak;
  assign dis_accept = ctl_wr && cmd.dis && cmd.snak && ena_q && !dis_q;
  assign ena_start  = ctl_wr && cmd.ena && !ena_q;
  assign data_fire  = tok_in && ena_q && !nak_sts_q && tx_ready && !infl_q;
  assign nak_evt    = nak_req_q && !nak_sts_q && !infl_q && !data_fire;
  assign dis_evt    = dis_q && nak_sts_q && !infl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nak_req_q    <= 1'b0;
      nak_sts_q    <= 1'b0;
      ena_q        <= 1'b0;
      dis_q        <= 1'b0;
      infl_q       <= 1'b0;
      flag_nak_q   <= 1'b0;
      flag_dis_q   <= 1'b0;
      resp_valid_q <= 1'b0;
      resp_q       <= RESP_NAK;
    end else begin
      resp_valid_q <= tok_in;
      resp_q       <= data_fire ? RESP_DATA : RESP_NAK;

      if (data_fire)     infl_q <= 1'b1;
      else if (pkt_done) infl_q <= 1'b0;

      if (set_nak)      nak_req_q <= 1'b1;
      else if (rel_nak) nak_req_q <= 1'b0;

      if (rel_nak)      nak_sts_q <= 1'b0;
      else if (nak_evt) nak_sts_q <= 1'b1;

      if (rel_nak)                    flag_nak_q <= 1'b0;
      else if (nak_evt)               flag_nak_q <= 1'b1;
      else if (clr_wr && clr_nakeff)  flag_nak_q <= 1'b0;

      if (dis_evt)        ena_q <= 1'b0;
      else if (ena_start) ena_q <= 1'b1;

      if (dis_evt)         dis_q <= 1'b0;
      else if (dis_accept) dis_q <= 1'b1;

      if (dis_evt)                    flag_dis_q <= 1'b1;
      else if (clr_wr && clr_disdone) flag_dis_q <= 1'b0;
    end
  end

  assign resp_valid   = resp_valid_q;
  assign resp_data    = (resp_q == RESP_DATA);
  assign nak_sts      = nak_sts_q;
  assign ep_ena       = ena_q;
  assign ep_dis       = dis_q;
  assign flag_nakeff  = flag_nak_q;
  assign flag_disdone = flag_dis_q;

  // R3: a token seen while NAK status is set is answered with NAK
  a_r3_nak_answer: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_in && nak_sts_q) |=> (resp_valid_q && resp_q == RESP_NAK));

  // R2: the NAK-effective flag never rises without NAK status
  a_r2_flag_with_sts: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_nak_q) |-> nak_sts_q);

  // R6: a pending disable exists only on an enabled endpoint
  a_r6_dis_needs_ena: assert property (@(posedge clk) disable iff (!rst_n)
    dis_q |-> ena_q);

  // R7: completion clears both bits and raises the flag together
  a_r7_dis_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    dis_evt |=> (!ena_q && !dis_q && flag_dis_q));

  // R3: no DATA while a packet is still in flight
  a_r3_one_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
    (infl_q && !pkt_done && tok_in) |=> !resp_data);

endmodule

// File: rtl/in_ep_xfer_cnt.sv
module in_ep_xfer_cnt #(
  parameter int LEN_W  = 11,
  parameter int PKT_W  = 10,
  parameter int BYTE_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              add_en,
  input  logic              clr_en,
  input  logic [LEN_W-1:0]  len,
  output logic [PKT_W-1:0]  pkts,
  output logic [BYTE_W-1:0] bytes
);

  function automatic logic [BYTE_W-1:0] add_bytes(input logic [BYTE_W-1:0] acc,
                                                  input logic [LEN_W-1:0]  l);
    return acc + BYTE_W'(l);
  endfunction

  function automatic logic [PKT_W-1:0] inc_pkts(input logic [PKT_W-1:0] acc);
    return acc + PKT_W'(1);
  endfunction

  logic [PKT_W-1:0]  pkts_q;
  logic [BYTE_W-1:0] bytes_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr_en) begin
      pkts_q  <= '0;
      bytes_q <= '0;
    end else if (add_en) begin
      pkts_q  <= inc_pkts(pkts_q);
      bytes_q <= add_bytes(bytes_q, len);
    end
  end

  assign pkts  = pkts_q;
  assign bytes = bytes_q;

  // R8: counts hold unless a packet is sent or a fresh enable clears them
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!add_en && !clr_en) |=> ($stable(pkts_q) && $stable(bytes_q)));

  // R8: enable from disabled restarts the count
  a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> (pkts_q == '0 && bytes_q == '0));

endmodule

// File: rtl/in_ep_flush.sv
module in_ep_flush #(
  parameter int NUM_FIFO  = 4,
  parameter int FLUSH_CYC = 8,
  localparam int FIFO_W   = (NUM_FIFO > 1) ? $clog2(NUM_FIFO) : 1,
  localparam int FC_W     = $clog2(FLUSH_CYC + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_wr,
  input  logic [FIFO_W-1:0]   sel,
  output logic                busy,
  output logic [NUM_FIFO-1:0] force_empty
);

  logic              busy_q;
  logic [FIFO_W-1:0] sel_q;
  logic [FC_W-1:0]   cnt_q;
  logic              accept, finish;

  assign accept = start_wr && !busy_q;
  assign finish = busy_q && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sel_q  <= '0;
      cnt_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      sel_q  <= sel;
      cnt_q  <= FC_W'(FLUSH_CYC - 1);
    end else if (finish) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q - FC_W'(1);
    end
  end

  for (genvar i = 0; i < NUM_FIFO; i++) begin : g_force
    assign force_empty[i] = busy_q && (sel_q == FIFO_W'(i));
  end

  assign busy = busy_q;

  // checker: length of the current busy run
  logic [FC_W-1:0] run_len;
  always_ff @(posedge clk) begin
    if (!rst_n || !busy_q) run_len <= '0;
    else                   run_len <= run_len + FC_W'(1);
  end

  // R9: a flush never lasts longer than FLUSH_CYC cycles
  a_r9_flush_len: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (run_len < FC_W'(FLUSH_CYC)));

  // R9: a flush ends after exactly FLUSH_CYC cycles
  a_r9_flush_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && run_len == FC_W'(FLUSH_CYC - 1)) |=> !busy_q);

  // R9: at most one FIFO is forced empty
  a_r9_one_fifo: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(force_empty));

endmodule

// File: rtl/in_ep_ctrl.sv
module in_ep_ctrl
  import in_ep_pkg::*;
#(
  parameter int LEN_W     = 11,
  parameter int PKT_W     = 10,
  parameter int BYTE_W    = 19,
  parameter int NUM_FIFO  = 4,
  parameter int FLUSH_CYC = 8,
  localparam int FIFO_W   = (NUM_FIFO > 1) ? $clog2(NUM_FIFO) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctl_wr,
  input  logic                ctl_snak,
  input  logic                ctl_cnak,
  input  logic                ctl_ena,
  input  logic                ctl_dis,
  input  logic                int_clr_wr,
  input  logic                int_clr_nakeff,
  input  logic                int_clr_disdone,
  input  logic                unmask_nakeff,
  input  logic                unmask_disdone,
  input  logic                flush_wr,
  input  logic [FIFO_W-1:0]   flush_sel,
  input  logic                tok_in,
  input  logic [LEN_W-1:0]    tok_len,
  input  logic                tx_ready,
  input  logic                pkt_done,
  output logic                resp_valid,
  output logic                resp_data,
  output logic                nak_sts,
  output logic                ep_ena,
  output logic                ep_dis,
  output logic                flag_nakeff,
  output logic                flag_disdone,
  output logic                irq_nakeff,
  output logic                irq_disdone,
  output logic [PKT_W-1:0]    sent_pkts,
  output logic [BYTE_W-1:0]   sent_bytes,
  output logic                flush_busy,
  output logic [NUM_FIFO-1:0] fifo_force_empty
);

  ctl_cmd_t cmd;
  logic     data_fire, ena_start;

  assign cmd = '{snak: ctl_snak, cnak: ctl_cnak, ena: ctl_ena, dis: ctl_dis};

  in_ep_state u_state (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_wr      (ctl_wr),
    .cmd         (cmd),
    .clr_wr      (int_clr_wr),
    .clr_nakeff  (int_clr_nakeff),
    .clr_disdone (int_clr_disdone),
    .tok_in      (tok_in),
    .tx_ready    (tx_ready),
    .pkt_done    (pkt_done),
    .resp_valid  (resp_valid),
    .resp_data   (resp_data),
    .nak_sts     (nak_sts),
    .ep_ena      (ep_ena),
    .ep_dis      (ep_dis),
    .flag_nakeff (flag_nakeff),
    .flag_disdone(flag_disdone),
    .data_fire   (data_fire),
    .ena_start   (ena_start)
  );

  in_ep_xfer_cnt #(.LEN_W(LEN_W), .PKT_W(PKT_W), .BYTE_W(BYTE_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .add_en(data_fire),
    .clr_en(ena_start),
    .len   (tok_len),
    .pkts  (sent_pkts),
    .bytes (sent_bytes)
  );

  in_ep_flush #(.NUM_FIFO(NUM_FIFO), .FLUSH_CYC(FLUSH_CYC)) u_flush (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_wr   (flush_wr),
    .sel        (flush_sel),
    .busy       (flush_busy),
    .force_empty(fifo_force_empty)
  );

  assign irq_nakeff  = flag_nakeff && unmask_nakeff;
  assign irq_disdone = flag_disdone && unmask_disdone;

  // R4: an interrupt never appears without its flag
  a_r4_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_nakeff |-> flag_nakeff) and (irq_disdone |-> flag_disdone)));

  // R1: disabled and quiet right after reset
  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (!ep_ena && !nak_sts && !flag_nakeff && !flag_disdone && !flush_busy));

endmodule

// File: tb/in_ep_ctrl_test.sv
module in_ep_ctrl_test;
  localparam int LEN_W = 11, PKT_W = 10, BYTE_W = 19, NUM_FIFO = 4, FLUSH_CYC = 8;
  localparam int FIFO_W = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_wr = 0, ctl_snak = 0, ctl_cnak = 0, ctl_ena = 0, ctl_dis = 0;
  logic int_clr_wr = 0, int_clr_nakeff = 0, int_clr_disdone = 0;
  logic unmask_nakeff = 0, unmask_disdone = 0;
  logic flush_wr = 0;
  logic [FIFO_W-1:0] flush_sel = '0;
  logic tok_in = 0, tx_ready = 0, pkt_done = 0;
  logic [LEN_W-1:0] tok_len = '0;
  logic resp_valid, resp_data, nak_sts, ep_ena, ep_dis, flag_nakeff, flag_disdone;
  logic irq_nakeff, irq_disdone, flush_busy;
  logic [PKT_W-1:0] sent_pkts;
  logic [BYTE_W-1:0] sent_bytes;
  logic [NUM_FIFO-1:0] fifo_force_empty;

  in_ep_ctrl uut (.*);

  always #10 clk = ~clk;  // 50 MHz

  int checks = 0, errors = 0;
  bit done = 0;

  // bench reference state
  bit m_ena, m_dis, m_req, m_sts, m_infl, m_fnak, m_fdis, m_rv, m_rd, m_fb;
  int m_fn, m_fc;
  int unsigned m_pk, m_by;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int unsigned mod_add(input int unsigned a, input int unsigned b, input int w);
    return (a + b) % (32'd1 << w);
  endfunction

  function automatic int force_mask(input bit busy, input int fn);
    return busy ? (1 << fn) : 0;
  endfunction

  task automatic model_reset();
    {m_ena, m_dis, m_req, m_sts, m_infl, m_fnak, m_fdis, m_rv, m_rd, m_fb} = '0;
    m_fn = 0; m_fc = 0; m_pk = 0; m_by = 0;
  endtask

  task automatic model_step();
    bit fire, setn, reln, nevt, devt, dacc, estart, faccept;
    fire    = tok_in && m_ena && !m_sts && tx_ready && !m_infl;
    setn    = ctl_wr && ctl_snak;
    reln    = ctl_wr && ctl_cnak && !ctl_snak;
    nevt    = m_req && !m_sts && !m_infl && !fire;
    devt    = m_dis && m_sts && !m_infl;
    dacc    = ctl_wr && ctl_dis && ctl_snak && m_ena && !m_dis;
    estart  = ctl_wr && ctl_ena && !m_ena;
    faccept = flush_wr && !m_fb;
    m_rv = tok_in; m_rd = fire;
    if (fire) m_infl = 1; else if (pkt_done) m_infl = 0;
    if (estart) begin m_pk = 0; m_by = 0; end
    else if (fire) begin m_pk = mod_add(m_pk, 1, PKT_W); m_by = mod_add(m_by, tok_len, BYTE_W); end
    if (reln) m_fnak = 0; else if (nevt) m_fnak = 1; else if (int_clr_wr && int_clr_nakeff) m_fnak = 0;
    if (reln) m_sts = 0; else if (nevt) m_sts = 1;
    if (setn) m_req = 1; else if (reln) m_req = 0;
    if (devt) m_fdis = 1; else if (int_clr_wr && int_clr_disdone) m_fdis = 0;
    if (devt) begin m_ena = 0; m_dis = 0; end
    else begin if (estart) m_ena = 1; if (dacc) m_dis = 1; end
    if (faccept) begin m_fb = 1; m_fn = flush_sel; m_fc = FLUSH_CYC - 1; end
    else if (m_fb) begin if (m_fc == 0) m_fb = 0; else m_fc--; end
  endtask

  task automatic compare_all(input string tag);
    chk(resp_valid == m_rv && (!m_rv || resp_data == m_rd), {tag, " R3 resp"},
        {resp_valid, resp_data}, {m_rv, m_rd});
    chk(nak_sts == m_sts && flag_nakeff == m_fnak, {tag, " R2 nak"},
        {nak_sts, flag_nakeff}, {m_sts, m_fnak});
    chk(ep_ena == m_ena && ep_dis == m_dis && flag_disdone == m_fdis, {tag, " R7 dis"},
        {ep_ena, ep_dis, flag_disdone}, {m_ena, m_dis, m_fdis});
    chk(irq_nakeff == (m_fnak && unmask_nakeff) && irq_disdone == (m_fdis && unmask_disdone),
        {tag, " R4 irq"}, {irq_nakeff, irq_disdone}, {m_fnak && unmask_nakeff, m_fdis && unmask_disdone});
    chk(sent_pkts == m_pk && sent_bytes == m_by, {tag, " R8 count"}, sent_bytes, m_by);
    chk(flush_busy == m_fb && int'(fifo_force_empty) == force_mask(m_fb, m_fn), {tag, " R9 flush"},
        fifo_force_empty, force_mask(m_fb, m_fn));
  endtask

  // one clock: model follows current inputs, outputs compared after the edge
  task automatic cycle(input string tag = "seq");
    model_step();
    @(posedge clk); #1;
    compare_all(tag);
  endtask

  task automatic idle();
    {ctl_wr, ctl_snak, ctl_cnak, ctl_ena, ctl_dis} = '0;
    {int_clr_wr, int_clr_nakeff, int_clr_disdone, flush_wr, tok_in, pkt_done} = '0;
  endtask

  task automatic ctl(input bit s, input bit c, input bit e, input bit d);
    ctl_wr = 1; ctl_snak = s; ctl_cnak = c; ctl_ena = e; ctl_dis = d;
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'h1234_5678;
    void'($urandom(seed));
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    chk(!ep_ena && !nak_sts && !flag_nakeff && !flag_disdone && !flush_busy && sent_pkts == 0
        && fifo_force_empty == 0, "R1 reset state", {ep_ena, nak_sts, flush_busy}, 0);
    rst_n = 1;

    // enable and send one packet
    ctl(0, 0, 1, 0); cycle("R8 enable"); idle();
    chk(ep_ena == 1 && sent_pkts == 0, "R8 enabled, count zero", ep_ena, 1);
    tok_in = 1; tx_ready = 1; tok_len = 64; cycle(); idle();
    chk(resp_valid && resp_data && sent_pkts == 1 && sent_bytes == 64, "R3/R8 first DATA", sent_bytes, 64);

    // NAK requested with a packet in flight: must wait
    ctl(1, 0, 0, 0); cycle(); idle();
    cycle();
    chk(nak_sts == 0 && flag_nakeff == 0, "R2 waits for boundary", nak_sts, 0);
    tok_in = 1; cycle(); idle();
    chk(resp_valid && !resp_data, "R3 NAK while in flight", resp_data, 0);
    pkt_done = 1; cycle(); idle();
    chk(nak_sts == 0, "R2 not before boundary edge", nak_sts, 0);
    cycle();
    chk(nak_sts == 1 && flag_nakeff == 1, "R2 effective after boundary", flag_nakeff, 1);
    chk(irq_nakeff == 0, "R4 masked", irq_nakeff, 0);
    unmask_nakeff = 1; #1;
    chk(irq_nakeff == 1 && flag_nakeff == 1, "R4 unmasked", irq_nakeff, 1);
    tok_in = 1; cycle(); idle();
    chk(resp_valid && !resp_data, "R3 NAK under NAK status", resp_data, 0);

    // release NAK, then set+clear together
    ctl(0, 1, 0, 0); cycle(); idle();
    chk(nak_sts == 0 && flag_nakeff == 0, "R5 clear NAK", {nak_sts, flag_nakeff}, 0);
    ctl(1, 1, 0, 0); cycle(); idle(); cycle();
    chk(nak_sts == 1, "R5 set wins over clear", nak_sts, 1);

    // disable attempts
    ctl(0, 0, 0, 1); cycle(); idle();
    chk(ep_dis == 0 && ep_ena == 1, "R6 bare disable ignored", ep_dis, 0);
    ctl(1, 0, 0, 1); cycle(); idle();
    chk(ep_dis == 1 && ep_ena == 1, "R6 disable accepted", ep_dis, 1);
    cycle();
    chk(!ep_ena && !ep_dis && flag_disdone, "R7 handshake done", {ep_ena, ep_dis, flag_disdone}, 1);
    chk(sent_pkts == 1 && sent_bytes == 64, "R8 count kept after disable", sent_bytes, 64);
    unmask_disdone = 1; #1;
    chk(irq_disdone == 1, "R4 disable irq", irq_disdone, 1);
    int_clr_wr = 1; int_clr_disdone = 1; cycle(); idle();
    chk(flag_disdone == 0 && flag_nakeff == 1, "R10 w1c one flag only", flag_disdone, 0);
    ctl(1, 0, 0, 1); cycle(); idle();
    chk(ep_dis == 0, "R6 disable on disabled ignored", ep_dis, 0);

    // flush
    flush_wr = 1; flush_sel = 2; cycle(); idle();
    chk(flush_busy && fifo_force_empty == 4'b0100, "R9 flush start", fifo_force_empty, 4);
    flush_wr = 1; flush_sel = 1; cycle(); idle();
    chk(fifo_force_empty == 4'b0100, "R9 write while busy ignored", fifo_force_empty, 4);
    repeat (FLUSH_CYC - 2) cycle();
    chk(flush_busy == 1, "R9 busy for last cycle", flush_busy, 1);
    cycle();
    chk(flush_busy == 0 && fifo_force_empty == 0, "R9 flush ended", flush_busy, 0);

    // re-enable restarts the count
    ctl(0, 1, 1, 0); cycle(); idle();
    chk(ep_ena && sent_pkts == 0 && sent_bytes == 0, "R8 re-enable clears", sent_pkts, 0);
    int_clr_wr = 1; int_clr_nakeff = 1; cycle(); idle();
    chk(flag_nakeff == 0, "R10 clear NAK flag", flag_nakeff, 0);

    // seeded random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      int r;
      idle();
      r = $urandom_range(0, 99);
      tok_in = ($urandom_range(0, 2) == 0);
      tok_len = LEN_W'($urandom_range(0, 1023));
      tx_ready = ($urandom_range(0, 3) != 0);
      pkt_done = ($urandom_range(0, 3) == 0);
      unmask_nakeff = $urandom_range(0, 1);
      unmask_disdone = $urandom_range(0, 1);
      if (r < 8) ctl($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1));
      else if (r < 12) ctl(0, 1, 0, 0);
      else if (r < 15) ctl(0, 0, 1, 0);
      if ($urandom_range(0, 9) == 0) begin
        int_clr_wr = 1; int_clr_nakeff = $urandom_range(0, 1); int_clr_disdone = $urandom_range(0, 1);
      end
      if ($urandom_range(0, 15) == 0) begin flush_wr = 1; flush_sel = FIFO_W'($urandom_range(0, 3)); end
      cycle("R10 random");
    end
    idle();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule